// File: doc/BRIEF.md
# Key-Gated Scratch Memory Guard

This block sits in front of an on-chip scratch SRAM. It holds one write-protect bit for each page of the memory. It checks every incoming write request against that protection and drops writes that target a guarded page. Each protect bit can only ever be set; nothing but a reset clears it.

A whole-memory clear is armed by writing two key bytes in a fixed order. The clear is then started through a control bit. While it runs, the block drives the memory write port itself, writing one zero word per clock, and holds off all outside writes.

The block also keeps a sticky parity-error flag. It holds a set of fault-routing lock bits that decide which fault sources reach a registered break output. Software reaches all state through a small synchronous register bus: 2-bit word address, write strobe, 32-bit write data and combinational read data.

Register map (word address):
- 0 is the page guard: a 1 in bit p protects page p.
- 1 is the key port, which compares the low 8 bits.
- 2 is control. Bit0 is an erase request when written. On read, bit1 is busy and bit2 is armed.
- 3 is faults. Bits[3:0] are lock bits and bit4 is the parity flag.

Top module: `sguard_top`

## Requirements
- R1: After reset the page guard reads 0, control reads 0 (not busy, not armed), the fault register reads 0, and `brk_out` and `wr_viol` are 0.
- R2: A write to address 0 ORs the low PAGES bits of write data into the page guard. Writing 0 to a bit never clears it, and reads return the current guard bits.
- R3: Writing key 0xCA and then key 0x53 to address 1 (low 8 bits compared) arms the block, and control bit2 then reads 1.
- R4: Any key write that does not match the expected next byte returns the sequencer to disarmed. In the armed state, a key write starts the sequence over (0xCA moves to the half-way state, and any other value disarms).
- R5: An erase request (write 1 to control bit0) while disarmed is ignored: busy stays 0 and the memory port sees no erase write.
- R6: An erase request while armed sets busy on the next cycle. For DEPTH cycles the block then drives `mem_we`=1 with `mem_wdata`=0 at addresses 0, 1, …, DEPTH-1 in ascending order. Busy falls on the cycle after the last word and the block returns to disarmed.
- R7: A write request to an unprotected page passes to the memory port in the same cycle, with the same address and data. The page of an address is addr / (DEPTH/PAGES).
- R8: A write request to a protected page is dropped (`mem_we`=0). `wr_viol` is 1 for exactly the one cycle after the request.
- R9: While busy, outside write requests are dropped and raise no `wr_viol`.
- R10: A `par_err` pulse sets fault bit4 from the next cycle on. Writing 1 to bit4 of address 3 clears it, but a `par_err` in the same cycle wins over the clear.
- R11: Fault bits[3:0] are set-only lock bits, one per source: bit0 ECC, bit1 core lockup, bit2 supply monitor, bit3 SRAM parity. `brk_out` equals, one cycle later, the OR over i of `fault_in[i]` AND lock bit i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register word address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| wr_req | input | 1 | Outside memory write request |
| wr_addr | input | AW | Word address of the write request |
| wr_data | input | DW | Data of the write request |
| wr_viol | output | 1 | One-cycle pulse after a dropped protected write |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory write address |
| mem_wdata | output | DW | Memory write data |
| par_err | input | 1 | Parity error detected pulse |
| fault_in | input | 4 | Fault sources (ECC, lockup, supply monitor, parity) |
| brk_out | output | 1 | Registered timer break request |

## Verification
The hardest situation to reach is an outside write that arrives in the middle of an erase. Seeing it needs the full key order, an accepted erase request and a write timed inside the DEPTH-cycle window. The bench walks the erase cycle by cycle. At fixed counts it injects writes to both a guarded and an open page, and checks that the port address keeps following the erase counter and that no violation appears. The key corner cases are also driven in order: a repeated first key, a wrong second key and a lone second key, all of which must leave the block disarmed. Random writes over a slowly growing set of guarded pages, mixed with random fault patterns, then exercise the drop rule and the break gating.

// File: rtl/sguard_pkg.sv
package sguard_pkg;
  typedef enum logic [1:0] {
    KS_IDLE = 2'd0,
    KS_HALF = 2'd1,
    KS_OPEN = 2'd2
  } key_state_e;

  localparam logic [1:0] A_GUARD = 2'd0;
  localparam logic [1:0] A_KEY   = 2'd1;
  localparam logic [1:0] A_CTRL  = 2'd2;
  localparam logic [1:0] A_FAULT = 2'd3;

  localparam logic [7:0] KEY_A = 8'hCA;
  localparam logic [7:0] KEY_B = 8'h53;

  localparam int NFAULT = 4;
  localparam int RW     = 32;
endpackage

// File: rtl/sguard_keyseq.sv
module sguard_keyseq
  import sguard_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_we,
  input  logic [7:0] key_val,
  input  logic       relock,
  output logic       armed
);
  key_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (relock) begin
      st_d = KS_IDLE;
    end else if (key_we) begin
      unique case (st_q)
        KS_HALF: st_d = (key_val == KEY_B) ? KS_OPEN : KS_IDLE;
        default: st_d = (key_val == KEY_A) ? KS_HALF : KS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= KS_IDLE;
    else        st_q <= st_d;
  end

  assign armed = (st_q == KS_OPEN);
endmodule

// File: rtl/sguard_eraser.sv
module sguard_eraser #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic          busy_d;
  logic [AW-1:0] cnt_q, cnt_d;
  logic          busy_q;

  assign done = busy_q && (cnt_q == LAST);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (busy_q) begin
      cnt_d = cnt_q + AW'(1);
      if (done) busy_d = 1'b0;
    end else if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      if (busy_q || start) cnt_q <= cnt_d;
    end
  end

  assign busy = busy_q;
  assign addr = cnt_q;
endmodule

// File: rtl/sguard_brk.sv
module sguard_brk #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic [N-1:0] set_bits,
  input  logic [N-1:0] fault_in,
  output logic [N-1:0] lock_q,
  output logic         brk
);
  logic brk_q, brk_d;

  for (genvar i = 0; i < N; i++) begin : g_lock
    logic lk_d;
    assign lk_d = lock_q[i] | (set_en & set_bits[i]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lock_q[i] <= 1'b0;
      else if (set_en) lock_q[i] <= lk_d;
    end
  end

  assign brk_d = |(fault_in & lock_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) brk_q <= 1'b0;
    else        brk_q <= brk_d;
  end

  assign brk = brk_q;
endmodule

// File: rtl/sguard_top.sv
module sguard_top
  import sguard_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int PAGES = 32,
  parameter int DW    = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    reg_addr,
  input  logic          reg_we,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          wr_req,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          wr_viol,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          par_err,
  input  logic [3:0]    fault_in,
  output logic          brk_out
);
  localparam int PW    = $clog2(PAGES);
  localparam int SHIFT = AW - PW;

  logic             wr_guard, wr_key, wr_ctrl, wr_fault;
  logic [PAGES-1:0] guard_q, guard_d;
  logic             flag_q, flag_d;
  logic             viol_q, viol_d;
  logic             armed, busy, done, start;
  logic [AW-1:0]    er_addr;
  logic [PW-1:0]    wr_page;
  logic             hit;
  logic [NFAULT-1:0] lock_q;

  assign wr_guard = reg_we && (reg_addr == A_GUARD);
  assign wr_key   = reg_we && (reg_addr == A_KEY);
  assign wr_ctrl  = reg_we && (reg_addr == A_CTRL);
  assign wr_fault = reg_we && (reg_addr == A_FAULT);

  assign start = wr_ctrl && reg_wdata[0] && armed && !busy;

  sguard_keyseq u_key (
    .clk     (clk),
    .rst_n   (rst_n),
    .key_we  (wr_key),
    .key_val (reg_wdata[7:0]),
    .relock  (done),
    .armed   (armed)
  );

  sguard_eraser #(.DEPTH(DEPTH), .AW(AW)) u_erase (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done),
    .addr  (er_addr)
  );

  sguard_brk #(.N(NFAULT)) u_brk (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (wr_fault),
    .set_bits (reg_wdata[NFAULT-1:0]),
    .fault_in (fault_in),
    .lock_q   (lock_q),
    .brk      (brk_out)
  );

  // page guard: set-only
  assign guard_d = guard_q | reg_wdata[PAGES-1:0];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        guard_q <= '0;
    else if (wr_guard) guard_q <= guard_d;
  end

  // parity flag: set wins over write-1-to-clear
  assign flag_d = par_err | (flag_q & ~(wr_fault & reg_wdata[NFAULT]));
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  // write-request check
  assign wr_page = PW'(wr_addr >> SHIFT);
  assign hit     = guard_q[wr_page];
  assign viol_d  = wr_req && !busy && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) viol_q <= 1'b0;
    else        viol_q <= viol_d;
  end
  assign wr_viol = viol_q;

  always_comb begin
    if (busy) begin
      mem_we    = 1'b1;
      mem_addr  = er_addr;
      mem_wdata = '0;
    end else begin
      mem_we    = wr_req && !hit;
      mem_addr  = wr_addr;
      mem_wdata = wr_data;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_GUARD: reg_rdata[PAGES-1:0] = guard_q;
      A_CTRL:  reg_rdata[2:1]       = {armed, busy};
      A_FAULT: reg_rdata[NFAULT:0]  = {flag_q, lock_q};
      default: reg_rdata            = '0;
    endcase
  end
endmodule

// File: rtl/sguard_chk.sv
module sguard_chk #(
  parameter int DEPTH = 64,
  parameter int PAGES = 32,
  parameter int DW    = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_req,
  input logic [AW-1:0]    wr_addr,
  input logic             wr_viol,
  input logic             mem_we,
  input logic [DW-1:0]    mem_wdata,
  input logic             par_err,
  input logic [3:0]       fault_in,
  input logic             brk_out,
  input logic             busy,
  input logic             armed,
  input logic             flag_q,
  input logic [PAGES-1:0] guard_q,
  input logic [3:0]       lock_q
);
  localparam int SHIFT = AW - $clog2(PAGES);
  logic guarded_req;
  assign guarded_req = wr_req && !busy && guard_q[wr_addr >> SHIFT];

  p_guard_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((guard_q & $past(guard_q)) == $past(guard_q)));

  p_erase_needs_key_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(armed));

  p_erase_relocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !armed);

  p_erase_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (mem_we && mem_wdata == '0));

  p_drop_guarded_r8: assert property (@(posedge clk) disable iff (!rst_n)
    guarded_req |-> !mem_we);

  p_viol_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    guarded_req |=> wr_viol);

  p_no_viol_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !wr_viol);

  p_flag_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |=> flag_q);

  p_lock_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lock_q & $past(lock_q)) == $past(lock_q)));

  p_brk_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (brk_out == |($past(fault_in & lock_q))));
endmodule

bind sguard_top sguard_chk #(.DEPTH(DEPTH), .PAGES(PAGES), .DW(DW), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_req    (wr_req),
  .wr_addr   (wr_addr),
  .wr_viol   (wr_viol),
  .mem_we    (mem_we),
  .mem_wdata (mem_wdata),
  .par_err   (par_err),
  .fault_in  (fault_in),
  .brk_out   (brk_out),
  .busy      (busy),
  .armed     (armed),
  .flag_q    (flag_q),
  .guard_q   (guard_q),
  .lock_q    (lock_q)
);

// File: tb/sguard_top_tb.sv
module sguard_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam int PAGES = 32;
  localparam int DW    = 32;
  localparam int AW    = $clog2(DEPTH);
  localparam int WPP   = DEPTH / PAGES;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    reg_addr = '0;
  logic          reg_we = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          wr_req = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_viol;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          par_err = 1'b0;
  logic [3:0]    fault_in = '0;
  logic          brk_out;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;
  logic [31:0] exp_guard = '0;
  logic [3:0]  exp_lock  = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sguard_top #(.DEPTH(DEPTH), .PAGES(PAGES), .DW(DW)) u_dut (.*);

  function automatic int page_of(logic [AW-1:0] a);
    return int'(a) / WPP;
  endfunction

  function automatic logic brk_of(logic [3:0] f, logic [3:0] l);
    return |(f & l);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic reg_wr(logic [1:0] a, logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    step();
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic reg_rd(logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'h5eed_c0de));
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    reg_rd(2'd0, rd); chk("R1 guard", rd, 0);
    reg_rd(2'd2, rd); chk("R1 ctrl", rd, 0);
    reg_rd(2'd3, rd); chk("R1 fault", rd, 0);
    chk("R1 brk", brk_out, 0);
    chk("R1 viol", wr_viol, 0);

    // R7 open write passes
    wr_req = 1; wr_addr = 6'd5; wr_data = 32'hA5A5_0001; #1;
    chk("R7 we", mem_we, 1);
    chk("R7 addr", mem_addr, 5);
    chk("R7 data", mem_wdata, 32'hA5A5_0001);
    step(); wr_req = 0;
    chk("R7 no viol", wr_viol, 0);

    // R2 set-only guard
    reg_wr(2'd0, 32'h0000_0005); exp_guard = 32'h5;
    reg_rd(2'd0, rd); chk("R2 set", rd, exp_guard);
    reg_wr(2'd0, 32'h0);
    reg_rd(2'd0, rd); chk("R2 no clear", rd, exp_guard);
    reg_wr(2'd0, 32'h8000_0000); exp_guard |= 32'h8000_0000;
    reg_rd(2'd0, rd); chk("R2 or", rd, exp_guard);

    // R8 guarded write dropped, one-cycle pulse
    wr_req = 1; wr_addr = 6'd4; wr_data = 32'hDEAD; #1;
    chk("R8 dropped", mem_we, 0);
    chk("R8 not yet", wr_viol, 0);
    step(); wr_req = 0;
    chk("R8 viol", wr_viol, 1);
    step();
    chk("R8 one cycle", wr_viol, 0);

    // R5 erase while disarmed ignored
    reg_wr(2'd2, 32'h1);
    reg_rd(2'd2, rd); chk("R5 busy", rd, 0);
    chk("R5 mem_we", mem_we, 0);
    step();
    reg_rd(2'd2, rd); chk("R5 busy later", rd, 0);

    // R3 / R4 key order
    reg_wr(2'd1, 32'hCA); reg_wr(2'd1, 32'h53);
    reg_rd(2'd2, rd); chk("R3 armed", rd, 32'h4);
    reg_wr(2'd1, 32'h11);
    reg_rd(2'd2, rd); chk("R4 relock open", rd, 0);
    reg_wr(2'd1, 32'hCA); reg_wr(2'd1, 32'h54);
    reg_rd(2'd2, rd); chk("R4 wrong second", rd, 0);
    reg_wr(2'd1, 32'hCA); reg_wr(2'd1, 32'hCA); reg_wr(2'd1, 32'h53);
    reg_rd(2'd2, rd); chk("R4 repeated first", rd, 0);
    reg_wr(2'd1, 32'h53);
    reg_rd(2'd2, rd); chk("R4 lone second", rd, 0);
    reg_wr(2'd1, 32'hFFFF_FFCA); reg_wr(2'd1, 32'h1234_5653);
    reg_rd(2'd2, rd); chk("R3 low byte", rd, 32'h4);

    // R6 / R9 erase walk
    reg_wr(2'd2, 32'h1);
    reg_rd(2'd2, rd); chk("R6 busy armed", rd, 32'h6);
    for (int i = 0; i < DEPTH; i++) begin
      if (i == 3) begin wr_req = 1; wr_addr = 6'd10; wr_data = 32'hFFFF; end
      if (i == 7) begin wr_req = 1; wr_addr = 6'd4;  wr_data = 32'hFFFF; end
      #1;
      if (mem_we !== 1'b1 || mem_addr !== AW'(i) || mem_wdata !== '0) begin
        chk("R6 erase word", {mem_we, 7'd0, 18'd0, mem_addr}, {1'b1, 7'd0, 18'd0, AW'(i)});
        chk("R6 erase data", mem_wdata, 0);
      end else checks++;
      step();
      if (i == 3 || i == 7) begin
        wr_req = 0;
        chk("R9 no viol busy", wr_viol, 0);
      end
    end
    reg_rd(2'd2, rd); chk("R6 done relocked", rd, 0);
    chk("R6 port idle", mem_we, 0);

    // R10 parity flag
    par_err = 1; step(); par_err = 0;
    reg_rd(2'd3, rd); chk("R10 set", rd, 32'h10);
    reg_wr(2'd3, 32'h10);
    reg_rd(2'd3, rd); chk("R10 clear", rd, 0);
    par_err = 1; reg_wr(2'd3, 32'h10); par_err = 0;
    reg_rd(2'd3, rd); chk("R10 set wins", rd, 32'h10);
    reg_wr(2'd3, 32'h10);

    // R11 lock bits and break
    fault_in = 4'hF; step();
    chk("R11 unlocked src", brk_out, 0);
    fault_in = 4'h0;
    reg_wr(2'd3, 32'h5); exp_lock = 4'h5;
    reg_wr(2'd3, 32'h0);
    reg_rd(2'd3, rd); chk("R11 sticky", rd, 32'h5);
    fault_in = 4'b0010; step();
    chk("R11 masked", brk_out, 0);
    fault_in = 4'b0100; #1;
    chk("R11 registered", brk_out, 0);
    step();
    chk("R11 pass", brk_out, 1);
    fault_in = 4'h0; step();

    // random mix: R7 R8 R11
    for (int n = 0; n < 400; n++) begin
      int p;
      logic exp_drop;
      if (($urandom % 8) == 0) begin
        logic [31:0] m;
        m = 32'h1 << ($urandom % PAGES);
        fault_in = 4'h0;
        reg_wr(2'd0, m); exp_guard |= m;
      end
      if (($urandom % 32) == 0) begin
        logic [3:0] l;
        l = 4'($urandom);
        fault_in = 4'h0;
        reg_wr(2'd3, {28'd0, l}); exp_lock |= l;
      end
      wr_req   = 1;
      wr_addr  = AW'($urandom);
      wr_data  = $urandom;
      fault_in = 4'($urandom);
      p = page_of(wr_addr);
      exp_drop = exp_guard[p];
      #1;
      chk(exp_drop ? "R8 rnd drop" : "R7 rnd pass", mem_we, !exp_drop);
      step();
      chk("R8 rnd viol", wr_viol, exp_drop);
      chk("R11 rnd brk", brk_out, brk_of(fault_in, exp_lock));
      wr_req = 0;
    end

    finish_run();
  end
endmodule